// File: doc/BRIEF.md
# Packed accumulator round-and-clamp readout

This block turns a bank of wide per-lane accumulators into one 64-bit packed word. In byte format there are eight 24-bit signed accumulators, each narrowed to an 8-bit lane. In halfword format there are four 48-bit signed accumulators, each narrowed to a 16-bit lane. Each lane is shifted right by its own amount, rounded by the selected mode, and saturated to the lane range. The 64-bit result is registered and appears one clock after the operands.

The shift amount comes from one of three sources. It can be a full shift vector (one amount per lane), one element of that vector broadcast to every lane, or a small immediate. Six rounding modes are available: round half away from zero, round half to even, and truncation, each in a signed and an unsigned variant. Byte format accepts only the unsigned variants. An operand combination that has no defined result raises an unpredictable-result flag. The accumulators themselves are written elsewhere; this block only reads them.

Top module: `acc_round_clamp`

## Requirements
- R1: `round_mode` selects 0 away-signed, 1 away-unsigned, 2 even-signed, 3 even-unsigned, 4 truncate-signed, 5 truncate-unsigned. The following pairs are invalid: codes 6 and 7 in either format, and the even codes 0, 2 and 4 in byte format (`fmt_sel[0]`=0). An invalid pair gives an all-zero result with `unpredictable`=1. A valid byte-format pair always gives `unpredictable`=0.
- R2: The shift source is set by `fmt_sel`. If `fmt_sel[4]`=0, one element of `shift_vec` is broadcast to all lanes; its index is `fmt_sel[3:1]` in byte format and `fmt_sel[3:2]` in halfword format. If `fmt_sel[4:3]`=2'b10, lane i uses lane i of `shift_vec`. If `fmt_sel[4:3]`=2'b11, every lane uses the zero-extended `shift_imm`. A byte shift amount is an unsigned 8-bit value. A halfword shift amount is a signed 16-bit value. `fmt_sel[0]` selects the format: 0 byte, 1 halfword.
- R3: In round-half-away mode, the result is the accumulator divided by 2^s, rounded to nearest, with exact ties moving away from zero. For example, 5>>1 gives 3, -5>>1 gives -3, and -9>>2 gives -2.
- R4: In round-half-even mode, the result is rounded to nearest, with exact ties going to the even value. For example, 5>>1 gives 2, 7>>1 gives 4, and -5>>1 gives -2.
- R5: Truncation rounds toward zero. For example, -9>>2 gives -2 in the signed variant.
- R6: An unsigned mode applied to a negative accumulator gives 0 in that lane.
- R7: Signed results saturate to -32768..32767. Unsigned results saturate to 0..255 in byte lanes and 0..65535 in halfword lanes.
- R8: A shift of zero adds no rounding increment. The lane is the accumulator value, saturated.
- R9: A lane whose shift amount is at least the accumulator width (24 or 48) gives 0.
- R10: A negative halfword shift amount zeroes its lane and sets `unpredictable`.
- R11: `result` and `unpredictable` are registered. They reflect the operands present at the previous rising clock edge. Synchronous `rst` drives both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_byte | input | 192 | Eight 24-bit signed accumulators; lane i at bits 24i+23:24i |
| acc_half | input | 192 | Four 48-bit signed accumulators; lane i at bits 48i+47:48i |
| round_mode | input | 3 | Rounding mode code (R1) |
| fmt_sel | input | 5 | Format bit and shift-source select (R2) |
| shift_vec | input | 64 | Packed shift amounts |
| shift_imm | input | 5 | Immediate shift amount |
| result | output | 64 | Packed rounded, clamped lanes |
| unpredictable | output | 1 | Result undefined for these operands |

## Verification
Every result is due exactly one rising edge after its operands are applied. The bench therefore changes the operands on a falling edge, lets one rising edge pass, and compares `result` and `unpredictable` on the following falling edge. No output is sampled at the edge where it changes. The embedded properties use the same one-cycle relation: they look at the operands in one cycle and the registered outputs in the next.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;
    typedef enum logic [2:0] {
        RM_AWAY_S  = 3'd0,
        RM_AWAY_U  = 3'd1,
        RM_EVEN_S  = 3'd2,
        RM_EVEN_U  = 3'd3,
        RM_TRUNC_S = 3'd4,
        RM_TRUNC_U = 3'd5
    } rmode_e;

    typedef enum logic [1:0] {
        SRC_ELEM = 2'd0,
        SRC_VEC  = 2'd1,
        SRC_IMM  = 2'd2
    } shsrc_e;

    function automatic shsrc_e decode_src(input logic [4:0] fsel);
        if (!fsel[4])      return SRC_ELEM;
        else if (!fsel[3]) return SRC_VEC;
        else               return SRC_IMM;
    endfunction

    // A mode/format pair is legal only for codes 0..5, and byte format needs an unsigned code.
    function automatic logic pair_invalid(input logic [2:0] mode, input logic is_half);
        return (mode > 3'd5) || (!is_half && !mode[0]);
    endfunction
endpackage

// File: rtl/acc_rnd_shsel.sv
module acc_rnd_shsel
    import acc_rnd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LW     = 8,
    parameter int IMM_W  = 5
) (
    input  logic [DATA_W-1:0]          vec,
    input  shsrc_e                     src,
    input  logic [$clog2(DATA_W/LW)-1:0] elem,
    input  logic [IMM_W-1:0]           imm,
    output logic [DATA_W-1:0]          shifts
);
    localparam int N = DATA_W / LW;

    logic [LW-1:0] bcast;
    assign bcast = vec[elem*LW +: LW];

    for (genvar i = 0; i < N; i++) begin : g_lane
        always_comb begin
            unique case (src)
                SRC_ELEM: shifts[i*LW +: LW] = bcast;
                SRC_VEC:  shifts[i*LW +: LW] = vec[i*LW +: LW];
                default:  shifts[i*LW +: LW] = LW'(imm);
            endcase
        end
    end
endmodule

// File: rtl/acc_rnd_lane.sv
module acc_rnd_lane #(
    parameter int AW        = 48,
    parameter int OW        = 16,
    parameter int SW        = 16,
    parameter bit SIGNED_SH = 1'b1
) (
    input  logic [AW-1:0] acc,
    input  logic [SW-1:0] shamt,
    input  logic [2:0]    rmode,
    output logic [OW-1:0] res,
    output logic          bad_shift
);
    localparam logic signed [AW:0] S_HI = $signed({{(AW-OW+2){1'b0}}, {(OW-1){1'b1}}});
    localparam logic signed [AW:0] S_LO = ~S_HI;
    localparam logic signed [AW:0] U_HI = $signed({{(AW-OW+1){1'b0}}, {OW{1'b1}}});

    logic                 neg, uns, half_bit, low_bits, inc, too_far;
    logic [AW-1:0]        mask_s, mask_h;
    logic signed [AW-1:0] q;
    logic signed [AW:0]   sum;

    always_comb begin
        bad_shift = SIGNED_SH && shamt[SW-1];
        too_far   = bad_shift || (int'(shamt) >= AW);
        mask_s    = ~({AW{1'b1}} << shamt);
        mask_h    = mask_s >> 1;
        half_bit  = |(acc & mask_s & ~mask_h);
        low_bits  = |(acc & mask_h);
        q         = $signed(acc) >>> shamt;
        neg       = acc[AW-1];
        uns       = rmode[0];
        case (rmode[2:1])
            2'd0:    inc = half_bit & (~neg | low_bits);
            2'd1:    inc = half_bit & (low_bits | q[0]);
            default: inc = neg & (half_bit | low_bits);
        endcase
        sum = {q[AW-1], q} + (AW+1)'(inc);
        if (too_far || (uns && neg))
            res = '0;
        else if (uns)
            res = (sum > U_HI) ? U_HI[OW-1:0] : sum[OW-1:0];
        else if (sum > S_HI)
            res = S_HI[OW-1:0];
        else if (sum < S_LO)
            res = S_LO[OW-1:0];
        else
            res = sum[OW-1:0];
    end
endmodule

// File: rtl/acc_round_clamp.sv
module acc_round_clamp
    import acc_rnd_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int BYTE_W     = 8,
    parameter int HALF_W     = 16,
    parameter int BYTE_ACC_W = 24,
    parameter int HALF_ACC_W = 48,
    parameter int IMM_W      = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DATA_W/BYTE_W*BYTE_ACC_W-1:0] acc_byte,
    input  logic [DATA_W/HALF_W*HALF_ACC_W-1:0] acc_half,
    input  logic [2:0]                   round_mode,
    input  logic [4:0]                   fmt_sel,
    input  logic [DATA_W-1:0]            shift_vec,
    input  logic [IMM_W-1:0]             shift_imm,
    output logic [DATA_W-1:0]            result,
    output logic                         unpredictable
);
    localparam int NB  = DATA_W / BYTE_W;
    localparam int NH  = DATA_W / HALF_W;
    localparam int IBW = $clog2(NB);
    localparam int IHW = $clog2(NH);

    shsrc_e            src;
    logic              is_half, bad_pair;
    logic [DATA_W-1:0] sh_b, sh_h, res_b, res_h, next_res;
    logic [NB-1:0]     badsh_b;
    logic [NH-1:0]     badsh_h;
    logic              next_flag;

    assign src      = decode_src(fmt_sel);
    assign is_half  = fmt_sel[0];
    assign bad_pair = pair_invalid(round_mode, is_half);

    acc_rnd_shsel #(.DATA_W(DATA_W), .LW(BYTE_W), .IMM_W(IMM_W)) u_sh_b (
        .vec(shift_vec), .src(src), .elem(fmt_sel[3 -: IBW]), .imm(shift_imm), .shifts(sh_b));
    acc_rnd_shsel #(.DATA_W(DATA_W), .LW(HALF_W), .IMM_W(IMM_W)) u_sh_h (
        .vec(shift_vec), .src(src), .elem(fmt_sel[3 -: IHW]), .imm(shift_imm), .shifts(sh_h));

    for (genvar i = 0; i < NB; i++) begin : g_byte
        acc_rnd_lane #(.AW(BYTE_ACC_W), .OW(BYTE_W), .SW(BYTE_W), .SIGNED_SH(1'b0)) u_lane (
            .acc(acc_byte[i*BYTE_ACC_W +: BYTE_ACC_W]), .shamt(sh_b[i*BYTE_W +: BYTE_W]),
            .rmode(round_mode), .res(res_b[i*BYTE_W +: BYTE_W]), .bad_shift(badsh_b[i]));
    end

    for (genvar i = 0; i < NH; i++) begin : g_half
        acc_rnd_lane #(.AW(HALF_ACC_W), .OW(HALF_W), .SW(HALF_W), .SIGNED_SH(1'b1)) u_lane (
            .acc(acc_half[i*HALF_ACC_W +: HALF_ACC_W]), .shamt(sh_h[i*HALF_W +: HALF_W]),
            .rmode(round_mode), .res(res_h[i*HALF_W +: HALF_W]), .bad_shift(badsh_h[i]));
    end

    always_comb begin
        if (bad_pair) begin
            next_res  = '0;
            next_flag = 1'b1;
        end else if (is_half) begin
            next_res  = res_h;
            next_flag = |badsh_h;
        end else begin
            next_res  = res_b;
            next_flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result        <= '0;
            unpredictable <= 1'b0;
        end else begin
            result        <= next_res;
            unpredictable <= next_flag;
        end
    end

    // R1: an invalid pair yields zero lanes and the flag one cycle later
    p_bad_pair_r1: assert property (@(posedge clk) disable iff (rst)
        (round_mode > 3'd5 || (!fmt_sel[0] && !round_mode[0])) |=> (result == '0 && unpredictable));

    // R1: a legal byte-format pair never raises the flag
    p_byte_ok_r1: assert property (@(posedge clk) disable iff (rst)
        (!fmt_sel[0] && round_mode[0] && round_mode <= 3'd5) |=> !unpredictable);

    for (genvar i = 0; i < NH; i++) begin : g_chk_h
        // R6: unsigned mode on a negative halfword accumulator gives a zero lane
        p_neg_unsigned_r6: assert property (@(posedge clk) disable iff (rst)
            (fmt_sel[0] && round_mode[0] && round_mode <= 3'd5 && acc_half[i*HALF_ACC_W + HALF_ACC_W - 1])
            |=> result[i*HALF_W +: HALF_W] == '0);
    end

    for (genvar i = 0; i < NB; i++) begin : g_chk_b
        // R8: zero immediate shift in truncate mode passes an in-range byte accumulator unchanged
        p_zero_shift_r8: assert property (@(posedge clk) disable iff (rst)
            (!fmt_sel[0] && fmt_sel[4:3] == 2'b11 && shift_imm == '0 && round_mode == 3'd5
             && acc_byte[i*BYTE_ACC_W + BYTE_W +: BYTE_ACC_W - BYTE_W] == '0)
            |=> result[i*BYTE_W +: BYTE_W] == $past(acc_byte[i*BYTE_ACC_W +: BYTE_W]));
    end
endmodule

// File: tb/acc_round_clamp_test.sv
`timescale 1ns/1ps
module acc_round_clamp_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [191:0] acc_byte = '0;
    logic [191:0] acc_half = '0;
    logic [2:0]   round_mode = '0;
    logic [4:0]   fmt_sel = '0;
    logic [63:0]  shift_vec = '0;
    logic [4:0]   shift_imm = '0;
    logic [63:0]  result;
    logic         unpredictable;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    acc_round_clamp uut (
        .clk(clk), .rst(rst), .acc_byte(acc_byte), .acc_half(acc_half),
        .round_mode(round_mode), .fmt_sel(fmt_sel), .shift_vec(shift_vec),
        .shift_imm(shift_imm), .result(result), .unpredictable(unpredictable));

    function automatic longint lane_ref(longint a, longint s, int m, int aw, int ow);
        longint q, rem, t, hi, lo;
        bit neg, h, l, inc;
        if (s < 0 || s >= aw) return 0;
        neg = (a < 0);
        if ((m % 2 == 1) && neg) return 0;
        if (s == 0) t = a;
        else begin
            q   = a >>> s;
            rem = a - (q << s);
            h   = ((rem >> (s - 1)) & 1) != 0;
            l   = (rem & ((64'sd1 << (s - 1)) - 1)) != 0;
            case (m / 2)
                0:       inc = h && (!neg || l);
                1:       inc = h && (l || q[0]);
                default: inc = neg && (h || l);
            endcase
            t = q + longint'(inc);
        end
        if (m % 2 == 1) begin hi = (64'sd1 << ow) - 1; lo = 0; end
        else begin hi = (64'sd1 << (ow - 1)) - 1; lo = -(64'sd1 << (ow - 1)); end
        if (t > hi) t = hi;
        if (t < lo) t = lo;
        return t;
    endfunction

    function automatic logic [64:0] model();
        logic [63:0] r = '0;
        bit flag = 0;
        bit hf = fmt_sel[0];
        int m = int'(round_mode);
        int n = hf ? 4 : 8;
        int lw = hf ? 16 : 8;
        longint s, a, v;
        int idx;
        if (m > 5 || (!hf && m % 2 == 0)) return {1'b1, 64'd0};
        for (int i = 0; i < n; i++) begin
            if (!fmt_sel[4]) idx = hf ? int'(fmt_sel[3:2]) : int'(fmt_sel[3:1]);
            else idx = i;
            if (fmt_sel[4] && fmt_sel[3]) s = longint'(shift_imm);
            else if (hf) s = longint'($signed(shift_vec[16*idx +: 16]));
            else s = longint'(shift_vec[8*idx +: 8]);
            if (hf) a = longint'($signed(acc_half[48*i +: 48]));
            else    a = longint'($signed(acc_byte[24*i +: 24]));
            if (s < 0) flag = 1;
            v = lane_ref(a, s, m, hf ? 48 : 24, lw);
            if (hf) r[16*i +: 16] = v[15:0];
            else    r[8*i +: 8]   = v[7:0];
        end
        return {flag, r};
    endfunction

    task automatic check(string tag);
        logic [64:0] exp;
        exp = model();
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if ({unpredictable, result} !== exp) begin
            n_fails++;
            $display("FAIL %s result %h flag %b expected %h flag %b",
                     tag, result, unpredictable, exp[63:0], exp[64]);
        end
    endtask

    task automatic set_half(longint a0, longint a1, longint a2, longint a3);
        acc_half[47:0]    = a0[47:0];
        acc_half[95:48]   = a1[47:0];
        acc_half[143:96]  = a2[47:0];
        acc_half[191:144] = a3[47:0];
    endtask

    task automatic set_byte_all(longint v);
        for (int i = 0; i < 8; i++) acc_byte[24*i +: 24] = v[23:0] + 24'(i);
    endtask

    initial begin
        #1_500_000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        n_checks++;
        if (result !== '0 || unpredictable !== 1'b0) begin
            n_fails++;
            $display("FAIL R11 reset result %h flag %b expected 0 0", result, unpredictable);
        end
        rst = 1'b0;

        // R3 away, halfword, immediate shifts 1 and 2
        fmt_sel = 5'b11001; round_mode = 3'd0; shift_imm = 5'd1;
        set_half(5, -5, 6, -3); check("R3");
        shift_imm = 5'd2; set_half(-9, -10, -11, 10); check("R3");
        // R4 even
        round_mode = 3'd2; shift_imm = 5'd1; set_half(5, 7, -5, -7); check("R4");
        // R5 truncate signed
        round_mode = 3'd4; shift_imm = 5'd2; set_half(-9, 9, -12, -1); check("R5");
        // R6 unsigned on negatives
        round_mode = 3'd1; shift_imm = 5'd1; set_half(-1, 100, -131072, 3); check("R6");
        // R7 signed halfword saturation, R8 zero shift
        round_mode = 3'd0; shift_imm = 5'd0; set_half(100000, -100000, 32767, -32768); check("R7");
        round_mode = 3'd3; set_half(70000, 65535, 1, 0); check("R7");
        // R7 byte unsigned saturation
        fmt_sel = 5'b11000; round_mode = 3'd5; shift_imm = 5'd0;
        set_byte_all(1000); acc_byte[23:0] = 24'd255; acc_byte[47:24] = 24'd256; check("R7");
        // R8 zero shift in away mode gives no increment
        round_mode = 3'd1; set_byte_all(7); check("R8");
        // R9 shift at/above width, byte vector source
        fmt_sel = 5'b10000; round_mode = 3'd3; set_byte_all(24'h7FFF00);
        shift_vec = {8'd0, 8'd1, 8'd255, 8'd22, 8'd23, 8'd25, 8'd24, 8'd30}; check("R9");
        // R10 negative halfword shift in vector source
        fmt_sel = 5'b10001; round_mode = 3'd0; set_half(1000, -1000, 77, 48'h7FFFFFFFFFFF);
        shift_vec = {16'd48, 16'd3, 16'hFFFF, 16'd2}; check("R10");
        // R1 invalid pairs
        fmt_sel = 5'b11000; round_mode = 3'd0; check("R1");
        fmt_sel = 5'b11001; round_mode = 3'd6; check("R1");
        fmt_sel = 5'b11000; round_mode = 3'd7; check("R1");
        // R2 element broadcast, byte index 5 and halfword index 2
        shift_vec = 64'h0807_0605_0403_0201;
        set_byte_all(24'h001234);
        fmt_sel = {1'b0, 3'd5, 1'b0}; round_mode = 3'd1; check("R2");
        shift_vec = 64'h0004_0003_0002_0001; set_half(1023, -1023, 4096, 6);
        fmt_sel = {1'b0, 2'd2, 1'b0, 1'b1}; round_mode = 3'd2; check("R2");

        // random mix across R2..R9
        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < 8; i++) begin
                longint v = longint'($urandom) & ((64'sd1 << ($urandom % 24)) - 1);
                if ($urandom % 2) v = -v;
                acc_byte[24*i +: 24] = v[23:0];
            end
            for (int i = 0; i < 4; i++) begin
                longint v = {32'd0, $urandom} << ($urandom % 16);
                v = v & ((64'sd1 << ($urandom % 48)) - 1);
                if ($urandom % 2) v = -v;
                acc_half[48*i +: 48] = v[47:0];
            end
            fmt_sel = 5'($urandom);
            if (fmt_sel[4:3] == 2'b10) fmt_sel[3] = ($urandom % 2 == 0);
            round_mode = ($urandom % 8 == 0) ? 3'($urandom) :
                         (fmt_sel[0] ? 3'($urandom % 6) : 3'(2 * ($urandom % 3) + 1));
            for (int i = 0; i < 8; i++) shift_vec[8*i +: 8] = 8'($urandom % 27);
            if ($urandom % 10 == 0) shift_vec[15:0] = 16'hFFF0;
            shift_imm = 5'($urandom);
            check("R2/R3/R4/R5/R7");
        end

        // R11 reset clears registered outputs
        set_half(123, 456, 789, 1); fmt_sel = 5'b11001; round_mode = 3'd4; shift_imm = 5'd0;
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        n_checks++;
        if (result !== '0 || unpredictable !== 1'b0) begin
            n_fails++;
            $display("FAIL R11 result %h flag %b expected 0 0", result, unpredictable);
        end
        rst = 1'b0;
        check("R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule